// File: doc/BRIEF.md
# Bus Access Tracer with Stall-Based Backpressure

This block sits beside an 8-bit processor bus and records every completed memory or I/O access as a fixed five-byte binary record in an internal buffer. A slower consumer drains the buffer through a byte-stream port. Each drain is requested with a one-cycle pulse and returns a packet. The packet opens with a six-byte header holding the sequence number of its first record and the number of record bytes that follow, so the consumer can tell whether any access went missing between packets.

Capture never drops an access. When the buffer comes close to full, the tracer drives the bus wait request low and holds the processor until the consumer has freed a configurable amount of space. Start and stop pulses clear the buffer, the pointers and the sequence count. While the tracer is stopped it records nothing and never stalls the bus. The bus inputs are assumed to be already synchronous to `clk`. `DEPTH` must be a power of two.

Top module: `busTracer`

## Requirements
- R1: An access is committed as one record in the cycle after the sampled read or write strobe returns high, provided that memory or I/O request was active together with the strobe. The record bytes are emitted in this order: address bits 7:0, address bits 15:8, the bus data byte, the return-data byte, then the flags byte. Address, data and return data are the values present in the last cycle the strobe was low.
- R2: In the flags byte, a set bit means the line was active: bit 0 read, bit 1 write, bit 2 memory request, bit 3 I/O request, bit 4 M1. Bit 6 is always 0. Bit 7 copies `retValid`.
- R3: Strobes with neither request active, and requests with no strobe (for example refresh), produce no record.
- R4: A packet is a six-byte header followed by records, oldest first. The header holds the 32-bit sequence number of the first record, least significant byte first, and then a 16-bit byte length equal to five times the record count, least significant byte first. Each byte is held stable while `outValid` is high and `outReady` is low.
- R5: A packet carries the smaller of the number of stored records and `MAX_PKT_RECS`. With an empty buffer it is the header alone, with length 0.
- R6: `waitReqN` goes low once one record slot or fewer is free. It returns high only once at least `RELEASE_FREE` slots are free. No access is lost while the processor is stalled.
- R7: The header sequence number advances by the number of records drained, so consecutive packets carry consecutive sequence numbers.
- R8: While stopped, bus accesses create no record and `waitReqN` stays high.
- R9: A start or stop pulse empties the buffer, aborts any packet in progress and restarts the sequence count at 0.
- R10: Flags bit 5 is set when `busWaitN` was seen low in any cycle of the access's strobe phase.
- R11: After reset the tracer is stopped, `waitReqN` is high and `outValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| traceStart | input | 1 | Pulse: clear and begin recording |
| traceStop | input | 1 | Pulse: clear and stop recording |
| busAddr | input | 16 | Processor address bus |
| busData | input | 8 | Processor data bus |
| mreqN | input | 1 | Memory request, active low |
| iorqN | input | 1 | I/O request, active low |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| m1N | input | 1 | Opcode-fetch marker, active low |
| busWaitN | input | 1 | Observed level of the shared wait line |
| retData | input | 8 | Return-data byte for the current access |
| retValid | input | 1 | Return-data byte is meaningful |
| waitReqN | output | 1 | Stall request to the processor, active low |
| pktReq | input | 1 | Pulse: start a readout packet |
| outByte | output | 8 | Readout byte |
| outValid | output | 1 | Readout byte present |
| outReady | input | 1 | Consumer accepts the byte |

## Verification
The hardest state to reach is a processor held in a stall while the consumer drains records. In that state the stalled access must commit partway through a packet, land behind the records being read, and carry the wait flag. The bench fills the buffer until the stall request falls. It then starts an access that loops on the wait line in parallel with a packet read. The release happens after the third record of that packet is freed, and the bench then checks that every access shows up exactly once, in order, with consecutive sequence numbers.

// File: rtl/busTracerPkg.sv
package busTracerPkg;
  localparam int ADDR_W    = 16;
  localparam int DATA_W    = 8;
  localparam int REC_BYTES = 5;
  localparam int HDR_BYTES = 6;
  localparam int SEQ_W     = 32;
  localparam int LEN_W     = 16;
  localparam int REC_W     = REC_BYTES * 8;
  localparam int HDR_W     = HDR_BYTES * 8;
  localparam int FLAG_WAIT = 5;

  typedef enum logic [1:0] {PK_IDLE, PK_HDR, PK_BODY} pkStateT;

  typedef struct packed {
    logic             clear;
    logic             capture;
    logic             commit;
    logic             pop;
    logic             snap;
    logic [LEN_W-1:0] pktLen;
    logic             selHdr;
    logic [2:0]       byteIdx;
  } trcStrobeT;
endpackage

// File: rtl/traceCtrl.sv
module traceCtrl
  import busTracerPkg::*;
#(
  parameter int DEPTH        = 2048,
  parameter int RELEASE_FREE = 64,
  parameter int MAX_PKT_RECS = 64,
  localparam int OCC_W       = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             traceStart,
  input  logic             traceStop,
  input  logic             mreqN,
  input  logic             iorqN,
  input  logic             rdN,
  input  logic             wrN,
  input  logic             pktReq,
  input  logic             outReady,
  output trcStrobeT        ctl,
  output logic             waitReqN,
  output logic             outValid,
  output logic             running,
  output logic [OCC_W-1:0] occ
);
  localparam int REM_W = $clog2(MAX_PKT_RECS + 1);

  logic             strbPrev, qualPrev, waitReq;
  logic             strbNow, qualNow, clear, runNext, fire, waitNext;
  logic [OCC_W-1:0] occNext;
  pkStateT          state;
  logic [2:0]       idx;
  logic [REM_W-1:0] remain;
  int               nRec;

  always_comb begin
    strbNow = !rdN || !wrN;
    qualNow = !mreqN || !iorqN;
    clear   = traceStart || traceStop;
    runNext = traceStart ? 1'b1 : (traceStop ? 1'b0 : running);
    outValid = (state != PK_IDLE);
    fire    = outValid && outReady;
    nRec    = (int'(occ) < MAX_PKT_RECS) ? int'(occ) : MAX_PKT_RECS;

    ctl.clear   = clear;
    ctl.capture = running && !clear && strbNow && qualNow;
    ctl.commit  = running && !clear && strbPrev && !strbNow && qualPrev;
    ctl.pop     = !clear && fire && (state == PK_BODY) && (int'(idx) == REC_BYTES - 1);
    ctl.snap    = !clear && (state == PK_IDLE) && pktReq;
    ctl.pktLen  = LEN_W'(nRec * REC_BYTES);
    ctl.selHdr  = (state == PK_HDR);
    ctl.byteIdx = idx;

    if (clear) occNext = '0;
    else occNext = occ + OCC_W'(ctl.commit) - OCC_W'(ctl.pop);

    if (!runNext) waitNext = 1'b0;
    else if (int'(occNext) >= DEPTH - 1) waitNext = 1'b1;
    else if (DEPTH - int'(occNext) >= RELEASE_FREE) waitNext = 1'b0;
    else waitNext = waitReq;

    waitReqN = !waitReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running  <= 1'b0;
      strbPrev <= 1'b0;
      qualPrev <= 1'b0;
      occ      <= '0;
      waitReq  <= 1'b0;
    end else begin
      running  <= runNext;
      strbPrev <= strbNow;
      qualPrev <= qualNow;
      occ      <= occNext;
      waitReq  <= waitNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= PK_IDLE;
      idx    <= '0;
      remain <= '0;
    end else if (clear) begin
      state  <= PK_IDLE;
      idx    <= '0;
      remain <= '0;
    end else begin
      case (state)
        PK_IDLE: if (ctl.snap) begin
          state  <= PK_HDR;
          idx    <= '0;
          remain <= REM_W'(nRec);
        end
        PK_HDR: if (fire) begin
          if (int'(idx) == HDR_BYTES - 1) begin
            idx   <= '0;
            state <= (remain == '0) ? PK_IDLE : PK_BODY;
          end else idx <= idx + 3'd1;
        end
        PK_BODY: if (fire) begin
          if (int'(idx) == REC_BYTES - 1) begin
            idx    <= '0;
            remain <= remain - REM_W'(1);
            if (remain == REM_W'(1)) state <= PK_IDLE;
          end else idx <= idx + 3'd1;
        end
        default: state <= PK_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/traceData.sv
module traceData
  import busTracerPkg::*;
#(
  parameter int DEPTH = 2048
) (
  input  logic              clk,
  input  logic              rstN,
  input  trcStrobeT         ctl,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  input  logic [DATA_W-1:0] retData,
  input  logic              retValid,
  input  logic              mreqN,
  input  logic              iorqN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic              m1N,
  input  logic              busWaitN,
  output logic [7:0]        outByte
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [ADDR_W-1:0] capAddr;
  logic [DATA_W-1:0] capData, capRet;
  logic [7:0]        capFlags;
  logic              waitSeen;
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [SEQ_W-1:0]  readSeq, hdrSeq;
  logic [LEN_W-1:0]  hdrLen;
  logic [REC_W-1:0]  mem [DEPTH];
  logic [REC_W-1:0]  newRec, rdRec;
  logic [HDR_W-1:0]  hdrFlat;
  logic [7:0]        hdrByte [8];
  logic [7:0]        recByte [8];

  always_comb begin
    newRec  = {capFlags | (8'(waitSeen) << FLAG_WAIT), capRet, capData, capAddr};
    rdRec   = mem[rdPtr];
    hdrFlat = {hdrLen, hdrSeq};
  end

  for (genvar g = 0; g < 8; g++) begin : g_bytes
    if (g < HDR_BYTES) begin : g_hdr
      assign hdrByte[g] = hdrFlat[g*8 +: 8];
    end else begin : g_hdrPad
      assign hdrByte[g] = 8'h00;
    end
    if (g < REC_BYTES) begin : g_rec
      assign recByte[g] = rdRec[g*8 +: 8];
    end else begin : g_recPad
      assign recByte[g] = 8'h00;
    end
  end

  assign outByte = ctl.selHdr ? hdrByte[ctl.byteIdx] : recByte[ctl.byteIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capAddr  <= '0;
      capData  <= '0;
      capRet   <= '0;
      capFlags <= '0;
      waitSeen <= 1'b0;
    end else if (ctl.clear || ctl.commit) begin
      waitSeen <= 1'b0;
    end else if (ctl.capture) begin
      capAddr  <= busAddr;
      capData  <= busData;
      capRet   <= retData;
      capFlags <= {retValid, 2'b00, !m1N, !iorqN, !mreqN, !wrN, !rdN};
      waitSeen <= waitSeen | !busWaitN;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.commit) mem[wrPtr] <= newRec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      readSeq <= '0;
      hdrSeq  <= '0;
      hdrLen  <= '0;
    end else if (ctl.clear) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      readSeq <= '0;
    end else begin
      if (ctl.commit) wrPtr <= wrPtr + PTR_W'(1);
      if (ctl.pop) begin
        rdPtr   <= rdPtr + PTR_W'(1);
        readSeq <= readSeq + SEQ_W'(1);
      end
      if (ctl.snap) begin
        hdrSeq <= readSeq;
        hdrLen <= ctl.pktLen;
      end
    end
  end
endmodule

// File: rtl/busTracer.sv
module busTracer
  import busTracerPkg::*;
#(
  parameter int DEPTH        = 2048,
  parameter int RELEASE_FREE = 64,
  parameter int MAX_PKT_RECS = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        traceStart,
  input  logic        traceStop,
  input  logic [15:0] busAddr,
  input  logic [7:0]  busData,
  input  logic        mreqN,
  input  logic        iorqN,
  input  logic        rdN,
  input  logic        wrN,
  input  logic        m1N,
  input  logic        busWaitN,
  input  logic [7:0]  retData,
  input  logic        retValid,
  output logic        waitReqN,
  input  logic        pktReq,
  output logic [7:0]  outByte,
  output logic        outValid,
  input  logic        outReady
);
  localparam int OCC_W = $clog2(DEPTH + 1);

  trcStrobeT        ctl;
  logic             running;
  logic [OCC_W-1:0] occ;

  traceCtrl #(
    .DEPTH(DEPTH), .RELEASE_FREE(RELEASE_FREE), .MAX_PKT_RECS(MAX_PKT_RECS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .traceStart(traceStart), .traceStop(traceStop),
    .mreqN(mreqN), .iorqN(iorqN), .rdN(rdN), .wrN(wrN),
    .pktReq(pktReq), .outReady(outReady), .ctl(ctl), .waitReqN(waitReqN),
    .outValid(outValid), .running(running), .occ(occ)
  );

  traceData #(.DEPTH(DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .ctl(ctl), .busAddr(busAddr), .busData(busData),
    .retData(retData), .retValid(retValid), .mreqN(mreqN), .iorqN(iorqN),
    .rdN(rdN), .wrN(wrN), .m1N(m1N), .busWaitN(busWaitN), .outByte(outByte)
  );
endmodule

// File: rtl/busTracerChk.sv
module busTracerChk
  import busTracerPkg::*;
#(
  parameter int DEPTH        = 2048,
  parameter int RELEASE_FREE = 64,
  localparam int OCC_W       = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             traceStart,
  input logic             traceStop,
  input logic             running,
  input logic [OCC_W-1:0] occ,
  input trcStrobeT        ctl,
  input logic             waitReqN,
  input logic             outValid,
  input logic             outReady,
  input logic [7:0]       outByte
);
  // R6: a commit never lands in a full buffer
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.commit |-> (int'(occ) < DEPTH));

  // R6: stall release only with enough free space
  p_release_space_r6: assert property (@(posedge clk) disable iff (!rstN)
    (running && $rose(waitReqN)) |-> (DEPTH - int'(occ) >= RELEASE_FREE));

  // R8: no stall and no record while stopped
  p_stopped_no_wait_r8: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> waitReqN);
  p_stopped_no_commit_r8: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> !ctl.commit);

  // R9: start or stop empties the buffer and aborts readout
  p_clear_empties_r9: assert property (@(posedge clk) disable iff (!rstN)
    (traceStart || traceStop) |=> (occ == '0) && !outValid);

  // R4: byte held while the consumer stalls
  p_hold_byte_r4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !traceStart && !traceStop) |=> outValid && $stable(outByte));

  // R7: records are freed only by accepted readout bytes
  p_pop_accepted_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pop |-> (outValid && outReady));
endmodule

bind busTracer busTracerChk #(.DEPTH(DEPTH), .RELEASE_FREE(RELEASE_FREE)) u_chk (
  .clk(clk), .rstN(rstN), .traceStart(traceStart), .traceStop(traceStop),
  .running(running), .occ(occ), .ctl(ctl), .waitReqN(waitReqN),
  .outValid(outValid), .outReady(outReady), .outByte(outByte)
);

// File: tb/busTracer_bench.sv
module busTracer_bench;
  localparam int DEPTH = 8;
  localparam int REL   = 4;
  localparam int MAXP  = 4;

  logic clk = 0;
  logic rstN = 0;
  logic traceStart = 0, traceStop = 0;
  logic [15:0] busAddr = '0;
  logic [7:0]  busData = '0, retData = '0;
  logic mreqN = 1, iorqN = 1, rdN = 1, wrN = 1, m1N = 1, retValid = 0;
  logic extWaitN = 1;
  logic busWaitN;
  logic waitReqN, outValid;
  logic pktReq = 0, outReady = 1;
  logic [7:0] outByte;

  int checks = 0, errors = 0;
  bit tbRunning = 0;
  bit done = 0;
  logic [39:0] expQ[$];
  int expSeq = 0;
  logic [7:0] pkt[$];

  always #10 clk = ~clk;
  assign busWaitN = waitReqN & extWaitN;

  busTracer #(.DEPTH(DEPTH), .RELEASE_FREE(REL), .MAX_PKT_RECS(MAXP)) u_busTracer (
    .clk(clk), .rstN(rstN), .traceStart(traceStart), .traceStop(traceStop),
    .busAddr(busAddr), .busData(busData), .mreqN(mreqN), .iorqN(iorqN),
    .rdN(rdN), .wrN(wrN), .m1N(m1N), .busWaitN(busWaitN), .retData(retData),
    .retValid(retValid), .waitReqN(waitReqN), .pktReq(pktReq),
    .outByte(outByte), .outValid(outValid), .outReady(outReady)
  );

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic pulseStart();
    @(negedge clk) traceStart = 1;
    @(negedge clk) traceStart = 0;
    tbRunning = 1; expQ.delete(); expSeq = 0;
  endtask

  task automatic pulseStop();
    @(negedge clk) traceStop = 1;
    @(negedge clk) traceStop = 0;
    tbRunning = 0; expQ.delete(); expSeq = 0;
  endtask

  // One bus access; the processor model loops while the wait line is low
  task automatic busAccess(input bit io, input bit wr, input bit m1, input logic [15:0] a,
                           input logic [7:0] d, input logic [7:0] r, input bit rv,
                           input int extCyc);
    bit seen = 0, w;
    int j = 0;
    @(negedge clk);
    busAddr = a; busData = d; retData = r; retValid = rv;
    m1N = !m1; mreqN = io; iorqN = !io;
    @(negedge clk);
    if (wr) wrN = 0; else rdN = 0;
    extWaitN = (extCyc > 0) ? 1'b0 : 1'b1;
    forever begin
      w = waitReqN & extWaitN;
      if (!w) seen = 1;
      @(negedge clk);
      j++;
      if (j >= extCyc) extWaitN = 1;
      if (w) break;
    end
    rdN = 1; wrN = 1;
    @(negedge clk);
    mreqN = 1; iorqN = 1; m1N = 1; retValid = 0;
    if (tbRunning)
      expQ.push_back({rv, 1'b0, seen, m1, io, !io, wr, !wr, r, d, a});
  endtask

  task automatic readPacket(input bit stall);
    int expN, len, k;
    logic [31:0] seq;
    logic [7:0] first;
    logic [39:0] got, ex;
    expN = (expQ.size() < MAXP) ? expQ.size() : MAXP;
    pkt.delete();
    @(negedge clk) pktReq = 1;
    @(negedge clk) pktReq = 0;
    if (stall) begin
      outReady = 0;
      first = outByte;
      for (int s = 0; s < 3; s++) begin
        @(negedge clk);
        check(outValid && outByte == first, "R4 byte held while not ready", outByte, first);
      end
      outReady = 1;
    end
    k = 0;
    while (outValid && k < 200) begin
      pkt.push_back(outByte);
      k++;
      @(negedge clk);
    end
    check(pkt.size() == 6 + expN * 5, "R5 packet byte count", pkt.size(), 6 + expN * 5);
    if (pkt.size() < 6) return;
    seq = {pkt[3], pkt[2], pkt[1], pkt[0]};
    len = int'({pkt[5], pkt[4]});
    check(seq == 32'(expSeq), "R7 header sequence", seq, expSeq);
    check(len == expN * 5, "R4 header length", len, expN * 5);
    for (int i = 0; i < expN; i++) begin
      ex = expQ.pop_front();
      got = '0;
      if (pkt.size() >= 6 + 5 * i + 5)
        for (int b = 0; b < 5; b++) got[b*8 +: 8] = pkt[6 + 5*i + b];
      check(got == ex, "R1 record contents", got, ex);
    end
    expSeq += expN;
  endtask

  task automatic t_reset();
    check(waitReqN == 1, "R11 wait high after reset", waitReqN, 1);
    check(outValid == 0, "R11 no readout after reset", outValid, 0);
  endtask

  task automatic t_basic();
    busAccess(0, 0, 1, 16'h0500, 8'hf3, 8'h00, 0, 0);
    busAccess(0, 1, 0, 16'h1234, 8'h55, 8'h00, 0, 0);
    // R3: refresh-like request with no strobe
    @(negedge clk) mreqN = 0; busAddr = 16'h0042;
    repeat (2) @(negedge clk);
    mreqN = 1;
    // R3: strobe with no request
    @(negedge clk) rdN = 0;
    repeat (2) @(negedge clk);
    rdN = 1;
    busAccess(1, 1, 0, 16'h0078, 8'h00, 8'h00, 0, 0);
    busAccess(1, 0, 0, 16'h0179, 8'h3c, 8'ha5, 1, 0);
    readPacket(1);
    // R2: flag encodings checked directly at their bit positions
    if (pkt.size() >= 26) begin
      check(pkt[10] == 8'h15, "R2 flags m1 memory read", pkt[10], 8'h15);
      check(pkt[15] == 8'h06, "R2 flags memory write", pkt[15], 8'h06);
      check(pkt[20] == 8'h0a, "R2 flags io write", pkt[20], 8'h0a);
      check(pkt[25] == 8'h89, "R2 flags io read with return", pkt[25], 8'h89);
    end else check(0, "R3 packet too short", pkt.size(), 26);
  endtask

  task automatic t_empty();
    readPacket(0);  // R5: header only
  endtask

  task automatic t_limit();
    for (int i = 0; i < 6; i++)
      busAccess(0, i % 2, 0, 16'(16'h4000 * (i % 4) + i), 8'(8'h44 + 57 * i), 8'h00, 0, 0);
    readPacket(0);  // R5: capped at four records
    readPacket(0);  // R7: sequence continues at 4 past previous start
  endtask

  task automatic t_backpressure();
    for (int i = 0; i < 7; i++)
      busAccess(0, 1, 0, 16'(16'h2000 + i), 8'(i), 8'h00, 0, 0);
    check(waitReqN == 0, "R6 wait low at one free slot", waitReqN, 0);
    fork
      busAccess(0, 1, 0, 16'h2fff, 8'hee, 8'h00, 0, 0);
      begin
        repeat (5) @(negedge clk);
        check(waitReqN == 0, "R6 wait held before draining", waitReqN, 0);
        readPacket(0);
      end
    join
    check(waitReqN == 1, "R6 wait released after drain", waitReqN, 1);
    check(expQ.size() == 4, "R6 stalled access kept", expQ.size(), 4);
    if (expQ.size() > 0)
      check(expQ[expQ.size()-1][37] == 1, "R10 stalled access flagged", expQ[expQ.size()-1][37], 1);
    readPacket(0);
  endtask

  task automatic t_extWait();
    busAccess(0, 0, 0, 16'h8000, 8'hb6, 8'h00, 0, 3);
    readPacket(0);
    if (pkt.size() >= 11)
      check(pkt[10] == 8'h25, "R10 wait flag bit 5 set", pkt[10], 8'h25);
    else check(0, "R10 packet too short", pkt.size(), 11);
  endtask

  task automatic t_stopped();
    pulseStop();
    for (int i = 0; i < 10; i++) begin
      busAccess(0, 1, 0, 16'(16'hc000 + i), 8'hef, 8'h00, 0, 0);
      check(waitReqN == 1, "R8 no stall while stopped", waitReqN, 1);
    end
    pulseStart();
    readPacket(0);  // R8: nothing recorded while stopped
  endtask

  task automatic t_clear();
    busAccess(0, 0, 0, 16'h0001, 8'h11, 8'h00, 0, 0);
    busAccess(0, 0, 0, 16'h0002, 8'h22, 8'h00, 0, 0);
    readPacket(0);
    busAccess(0, 0, 0, 16'h0003, 8'h33, 8'h00, 0, 0);
    busAccess(0, 0, 0, 16'h0004, 8'h44, 8'h00, 0, 0);
    pulseStop();
    pulseStart();   // R9: sequence and buffer restart
    busAccess(1, 0, 0, 16'h0005, 8'h55, 8'h00, 0, 0);
    readPacket(0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    pulseStart();
    t_basic();
    t_empty();
    t_limit();
    t_backpressure();
    t_extWait();
    t_stopped();
    t_clear();
    repeat (3) @(negedge clk);
    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    finishRun();
  end
endmodule